// File: doc/BRIEF.md
# Serial Port Register File with Delayed Interrupts

This block is a byte-wide register file that follows the programming model of the classic PC serial port. It decodes eight register offsets on a simple single-cycle host bus and connects them to a byte stream. Received bytes arrive on a valid/data pair and are consumed with a one-cycle pop strobe. Transmitted bytes leave on a valid/data pair in the same cycle as the host write. Baud timing, the divisor value, FIFOs and modem lines are not modelled. Divisor-latch accesses are accepted and have no effect.

Interrupts are never raised at once. Each source, receive and transmit, owns a restartable down-counter of `IRQ_DELAY` clock cycles. When an event arms a source's counter, the interrupt is posted only when that counter runs out, and only if the source's enable is still set at that moment. Posting sets the source's pending status, which the identification register shows, and raises the single level interrupt output.

The host bus is one access per cycle. Read data is combinational from the address. Side effects of reads and writes take place at the clock edge that ends the access.

Top module: `ser_regfile`

## Requirements
- R1: An access with a bus address of 8 or above raises `bus_err` in that cycle, changes no register and produces no stream strobe. An in-range access keeps `bus_err` low.
- R2: While line-control bit 7 is set, offsets 0 and 1 address the divisor latch. Reads there return 0x00. Writes there are discarded. Neither raises `tx_valid` or `rx_pop`, and the enable register keeps its value.
- R3: A read of offset 0 returns `rx_data` and pulses `rx_pop` when `rx_valid` is high. With `rx_valid` low it returns 0x00 and does not pop. Either way it clears the receive status and drops `irq` at that edge.
- R4: If `rx_valid` is high in the cycle after a data read and enable bit 0 is set, the receive counter is armed at the next edge. If `rx_valid` is low then, nothing is armed.
- R5: A write of offset 0 drives `tx_valid` high and `tx_data` to the written byte in that cycle. It clears the transmit status and drops `irq`, and it arms the transmit counter when enable bit 1 is set.
- R6: A write of offset 1 stores the enable byte, which offset 1 reads back. With bit 1 set the write arms the transmit counter. With bit 1 clear it cancels that counter, clears the transmit status and drops `irq` if that status was set.
- R7: A write of offset 1 with bit 0 set while `rx_valid` is high arms the receive counter. Any other write of offset 1 cancels that counter, clears the receive status and drops `irq` if that status was set.
- R8: `irq` rises exactly `IRQ_DELAY` clock edges after the edge that armed a counter. Arming a running counter restarts the full delay.
- R9: Offset 2 reads 0x00 while either status bit is set, and 0x01 while none is set. Writes there have no effect.
- R10: Offset 5 reads 0x61 while `rx_valid` is high and 0x60 while it is low. Bit 0 is data-ready, and bits 5 and 6 are always set.
- R11: Offset 3 stores and reads back a full byte. Offsets 4, 6 and 7 read 0x00, and writes to offsets 4 and 7 leave every readback unchanged.
- R12: When `rx_valid` goes from low to high while enable bit 0 is set, the receive counter is armed at that edge.
- R13: After reset, `irq` is low, the enable and line-control registers read 0x00, and offset 2 reads 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| bus_err | output | 1 | Access to a non-existent offset |
| rx_valid | input | 1 | A received byte is available |
| rx_data | input | 8 | Received byte |
| rx_pop | output | 1 | Consume the received byte |
| tx_valid | output | 1 | Byte being transmitted |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts edges from each arming access and checks `irq` one edge before and exactly at the expected rise. A counter that is off by one, or that keeps an old deadline when it is re-armed, shows up as an early or late rise. The bench re-arms the transmit counter halfway through its delay, so a design that does not restart would post too soon. After a data read it checks both outcomes of the one-cycle re-arm check, and it reads an empty receive register. A design that rearmed unconditionally would raise `irq` with no data waiting. A design that popped on an empty read would show a stray `rx_pop`. Divisor-latch and out-of-range writes are followed by readbacks of the enable and line-control registers, and disabling a source is followed by a wait past the full delay. This catches a design that leaks such writes into state, or one that lets a cancelled counter fire.

// File: rtl/ser_pkg.sv
package ser_pkg;

    typedef enum logic [2:0] {
        OFS_DATA  = 3'd0,
        OFS_IEN   = 3'd1,
        OFS_IID   = 3'd2,
        OFS_LCTL  = 3'd3,
        OFS_MCTL  = 3'd4,
        OFS_LSTAT = 3'd5,
        OFS_MSTAT = 3'd6,
        OFS_SCR   = 3'd7
    } ser_ofs_e;

    // interrupt source index, equal to its enable bit position
    localparam int SRC_RX = 0;
    localparam int SRC_TX = 1;
    localparam int NSRC   = 2;

    localparam int LCTL_DLAB_BIT = 7;

    typedef struct packed {
        logic ok;
        logic rd_data;
        logic wr_data;
        logic wr_ien;
        logic wr_lctl;
    } ser_dec_t;

    function automatic logic [7:0] lstat_byte(input logic avail);
        return {1'b0, 1'b1, 1'b1, 4'b0000, avail};
    endfunction

    function automatic logic [7:0] iid_byte(input logic pend);
        return pend ? 8'h00 : 8'h01;
    endfunction

endpackage

// File: rtl/ser_irq_timer.sv
module ser_irq_timer #(
    parameter int DELAY = 450
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic cancel,
    output logic expire
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (arm)           cnt_q <= CW'(DELAY);
        else if (cancel)        cnt_q <= '0;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    // last counting cycle; a restart or cancel in that cycle suppresses it
    assign expire = (cnt_q == CW'(1)) && !arm && !cancel;

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DELAY));

    // R8
    exp_idle_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/ser_rd_mux.sv
module ser_rd_mux
    import ser_pkg::*;
(
    input  ser_ofs_e   ofs,
    input  logic       dlab,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic [7:0] ien,
    input  logic [7:0] lctl,
    input  logic       pend,
    output logic [7:0] rdata
);
    always_comb begin
        rdata = 8'h00;
        unique case (ofs)
            OFS_DATA:  rdata = (!dlab && rx_valid) ? rx_data : 8'h00;
            OFS_IEN:   rdata = dlab ? 8'h00 : ien;
            OFS_IID:   rdata = iid_byte(pend);
            OFS_LCTL:  rdata = lctl;
            OFS_LSTAT: rdata = lstat_byte(rx_valid);
            default:   rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
    import ser_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int IRQ_DELAY = 450
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_err,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    logic [7:0]      ien_q, lctl_q;
    logic [NSRC-1:0] st_q;
    logic            irq_q, rxv_q, rechk_q;
    logic            in_rng, dlab;
    ser_ofs_e        ofs;
    ser_dec_t        dec;
    logic [NSRC-1:0] arm, cancel, expire, post, clr;
    logic            irq_drop;

    generate
        if (ADDR_W > 3) begin : g_rng
            assign in_rng = (bus_addr[ADDR_W-1:3] == '0);
        end else begin : g_full
            assign in_rng = 1'b1;
        end
    endgenerate

    assign ofs  = ser_ofs_e'(bus_addr[2:0]);
    assign dlab = lctl_q[LCTL_DLAB_BIT];

    always_comb begin
        dec         = '0;
        dec.ok      = bus_sel && in_rng;
        dec.rd_data = dec.ok && !bus_wr && ofs == OFS_DATA && !dlab;
        dec.wr_data = dec.ok &&  bus_wr && ofs == OFS_DATA && !dlab;
        dec.wr_ien  = dec.ok &&  bus_wr && ofs == OFS_IEN  && !dlab;
        dec.wr_lctl = dec.ok &&  bus_wr && ofs == OFS_LCTL;
    end

    assign bus_err  = bus_sel && !in_rng;
    assign rx_pop   = dec.rd_data && rx_valid;
    assign tx_valid = dec.wr_data;
    assign tx_data  = bus_wdata;

    // arming and cancelling of each source's delay counter
    always_comb begin
        arm[SRC_TX]    = (dec.wr_data && ien_q[SRC_TX]) ||
                         (dec.wr_ien && bus_wdata[SRC_TX]);
        cancel[SRC_TX] = dec.wr_ien && !bus_wdata[SRC_TX];
        arm[SRC_RX]    = dec.wr_ien ? (bus_wdata[SRC_RX] && rx_valid)
                                    : (ien_q[SRC_RX] && rx_valid && (rechk_q || !rxv_q));
        cancel[SRC_RX] = dec.wr_ien && !(bus_wdata[SRC_RX] && rx_valid);
        clr[SRC_RX]    = dec.rd_data || cancel[SRC_RX];
        clr[SRC_TX]    = dec.wr_data || cancel[SRC_TX];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_src
            ser_irq_timer #(.DELAY(IRQ_DELAY)) u_tmr (
                .clk    (clk),
                .rst    (rst),
                .arm    (arm[gi]),
                .cancel (cancel[gi]),
                .expire (expire[gi])
            );
            assign post[gi] = expire[gi] && ien_q[gi];

            always_ff @(posedge clk) begin
                if (rst)           st_q[gi] <= 1'b0;
                else if (clr[gi])  st_q[gi] <= 1'b0;
                else if (post[gi]) st_q[gi] <= 1'b1;
            end
        end
    endgenerate

    assign irq_drop = dec.rd_data || dec.wr_data ||
                      (cancel[SRC_RX] && st_q[SRC_RX]) ||
                      (cancel[SRC_TX] && st_q[SRC_TX]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ien_q   <= 8'h00;
            lctl_q  <= 8'h00;
            irq_q   <= 1'b0;
            rxv_q   <= 1'b0;
            rechk_q <= 1'b0;
        end else begin
            if (dec.wr_ien)  ien_q  <= bus_wdata;
            if (dec.wr_lctl) lctl_q <= bus_wdata;
            if (irq_drop)    irq_q  <= 1'b0;
            else if (|post)  irq_q  <= 1'b1;
            rxv_q   <= rx_valid;
            rechk_q <= dec.rd_data;
        end
    end

    assign irq = irq_q;

    ser_rd_mux u_mux (
        .ofs      (ofs),
        .dlab     (dlab),
        .rx_valid (rx_valid),
        .rx_data  (rx_data),
        .ien      (ien_q),
        .lctl     (lctl_q),
        .pend     (|st_q),
        .rdata    (bus_rdata)
    );

    // R1
    oob_keeps_lctl_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err |=> $stable(lctl_q));

    // R2
    dlab_keeps_ien_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.ok && bus_wr && dlab && ofs == OFS_IEN) |=> $stable(ien_q));

    // R3
    rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
        dec.rd_data |=> (!irq_q && !st_q[SRC_RX]));

    // R5
    wr_clears_chk: assert property (@(posedge clk) disable iff (rst)
        dec.wr_data |=> (!irq_q && !st_q[SRC_TX]));

    // R6
    tx_off_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.wr_ien && !bus_wdata[SRC_TX]) |=> !st_q[SRC_TX]);

    // R8
    irq_has_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> (|st_q));

    // R8
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> $past(|expire));

endmodule

// File: tb/sim_ser_regfile.sv
module sim_ser_regfile;
    localparam int AW = 4;
    localparam int D  = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_sel = 1'b0, bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          bus_err;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = 8'h00;
    logic          rx_pop, tx_valid, irq;
    logic [7:0]    tx_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ser_regfile #(.ADDR_W(AW), .IRQ_DELAY(D)) u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_pop(rx_pop), .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d,
                      output logic p, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1; d = bus_rdata; p = rx_pop; e = bus_err;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] v,
                      output logic t, output logic [7:0] td, output logic e);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        #1; t = tx_valid; td = tx_data; e = bus_err;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic t_reset;
        logic [7:0] d; logic p, e;
        chk("R13 irq", {7'b0, irq}, 8'h00);
        rd(4'd1, d, p, e); chk("R13 ien", d, 8'h00);
        rd(4'd3, d, p, e); chk("R13 lctl", d, 8'h00);
        rd(4'd2, d, p, e); chk("R13 iid", d, 8'h01);
        chk("R1 in-range err", {7'b0, e}, 8'h00);
    endtask

    task automatic t_regs;
        logic [7:0] d, td; logic p, e, t;
        wr(4'd3, 8'h1B, t, td, e);
        rd(4'd3, d, p, e); chk("R11 lctl readback", d, 8'h1B);
        wr(4'd7, 8'h5A, t, td, e);
        rd(4'd7, d, p, e); chk("R11 scratch", d, 8'h00);
        wr(4'd4, 8'h1A, t, td, e);
        rd(4'd4, d, p, e); chk("R11 mctl", d, 8'h00);
        rd(4'd6, d, p, e); chk("R11 mstat", d, 8'h00);
        rd(4'd3, d, p, e); chk("R11 lctl after ignored writes", d, 8'h1B);
        rd(4'd5, d, p, e); chk("R10 lstat empty", d, 8'h60);
        rx_valid = 1'b1; rx_data = 8'h77;
        rd(4'd5, d, p, e); chk("R10 lstat ready", d, 8'h61);
        rx_valid = 1'b0;
        wr(4'd2, 8'hC7, t, td, e);
        rd(4'd2, d, p, e); chk("R9 iid write ignored", d, 8'h01);
    endtask

    task automatic t_decode;
        logic [7:0] d, td; logic p, e, t;
        wr(4'd11, 8'h80, t, td, e);
        chk("R1 write err", {7'b0, e}, 8'h01);
        chk("R1 no tx", {7'b0, t}, 8'h00);
        wr(4'd9, 8'hFF, t, td, e);
        rd(4'd3, d, p, e); chk("R1 lctl kept", d, 8'h1B);
        rd(4'd1, d, p, e); chk("R1 ien kept", d, 8'h00);
        rd(4'd15, d, p, e); chk("R1 read err", {7'b0, e}, 8'h01);
    endtask

    task automatic t_dlab;
        logic [7:0] d, td; logic p, e, t;
        wr(4'd3, 8'h83, t, td, e);
        wr(4'd1, 8'hFF, t, td, e);
        wr(4'd0, 8'h41, t, td, e);
        chk("R2 no tx_valid", {7'b0, t}, 8'h00);
        rx_valid = 1'b1; rx_data = 8'h99;
        rd(4'd0, d, p, e);
        chk("R2 latch lo reads 0", d, 8'h00);
        chk("R2 no rx_pop", {7'b0, p}, 8'h00);
        rd(4'd1, d, p, e); chk("R2 latch hi reads 0", d, 8'h00);
        rx_valid = 1'b0;
        wr(4'd3, 8'h03, t, td, e);
        rd(4'd1, d, p, e); chk("R2 ien untouched", d, 8'h00);
        edges(D + 2);
        chk("R2 no irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_tx;
        logic [7:0] d, td; logic p, e, t;
        wr(4'd1, 8'h02, t, td, e);
        edges(D - 1); chk("R8 tx not early", {7'b0, irq}, 8'h00);
        edges(1);     chk("R8 tx on time", {7'b0, irq}, 8'h01);
        rd(4'd2, d, p, e); chk("R9 iid pending", d, 8'h00);
        rd(4'd1, d, p, e); chk("R6 ien readback", d, 8'h02);
        wr(4'd0, 8'h55, t, td, e);
        chk("R5 tx_valid", {7'b0, t}, 8'h01);
        chk("R5 tx_data", td, 8'h55);
        chk("R5 irq dropped", {7'b0, irq}, 8'h00);
        rd(4'd2, d, p, e); chk("R5 status cleared", d, 8'h01);
        edges(D - 2); chk("R5 rearm not early", {7'b0, irq}, 8'h00);
        edges(1);     chk("R5 rearm fires", {7'b0, irq}, 8'h01);
        wr(4'd0, 8'h11, t, td, e);
        edges(8);
        wr(4'd0, 8'h22, t, td, e);
        edges(D - 1); chk("R8 restart no early post", {7'b0, irq}, 8'h00);
        edges(1);     chk("R8 restart posts", {7'b0, irq}, 8'h01);
        wr(4'd1, 8'h00, t, td, e);
        chk("R6 disable drops irq", {7'b0, irq}, 8'h00);
        rd(4'd2, d, p, e); chk("R6 disable clears status", d, 8'h01);
        wr(4'd1, 8'h02, t, td, e);
        edges(5);
        wr(4'd1, 8'h00, t, td, e);
        edges(D + 2); chk("R6 cancel stops post", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_rx;
        logic [7:0] d, td; logic p, e, t;
        wr(4'd1, 8'h01, t, td, e);
        edges(D + 2); chk("R7 no data no arm", {7'b0, irq}, 8'h00);
        rx_data = 8'hA5; rx_valid = 1'b1;
        edges(D);     chk("R12 arrival not early", {7'b0, irq}, 8'h00);
        edges(1);     chk("R12 arrival posts", {7'b0, irq}, 8'h01);
        rd(4'd2, d, p, e); chk("R9 rx pending", d, 8'h00);
        rd(4'd0, d, p, e);
        chk("R3 data", d, 8'hA5);
        chk("R3 pop", {7'b0, p}, 8'h01);
        rx_data = 8'h3C;
        chk("R3 irq dropped", {7'b0, irq}, 8'h00);
        edges(D);     chk("R4 rearm not early", {7'b0, irq}, 8'h00);
        edges(1);     chk("R4 rearm posts", {7'b0, irq}, 8'h01);
        rd(4'd0, d, p, e);
        chk("R3 second byte", d, 8'h3C);
        rx_valid = 1'b0;
        edges(D + 3); chk("R4 no rearm when empty", {7'b0, irq}, 8'h00);
        rd(4'd2, d, p, e); chk("R3 status cleared", d, 8'h01);
        rd(4'd0, d, p, e);
        chk("R3 empty read", d, 8'h00);
        chk("R3 empty no pop", {7'b0, p}, 8'h00);
        wr(4'd1, 8'h00, t, td, e);
        rx_valid = 1'b1; rx_data = 8'h44;
        edges(D + 2); chk("R12 no arm when disabled", {7'b0, irq}, 8'h00);
        wr(4'd1, 8'h01, t, td, e);
        edges(D - 1); chk("R7 arm not early", {7'b0, irq}, 8'h00);
        edges(1);     chk("R7 arm posts", {7'b0, irq}, 8'h01);
        wr(4'd1, 8'h00, t, td, e);
        chk("R7 disable drops irq", {7'b0, irq}, 8'h00);
        wr(4'd1, 8'h01, t, td, e);
        edges(4);
        wr(4'd1, 8'h00, t, td, e);
        edges(D + 2); chk("R7 cancel stops post", {7'b0, irq}, 8'h00);
        rx_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        #2;
        t_reset();
        t_regs();
        t_decode();
        t_dlab();
        t_tx();
        t_rx();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule